// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block models the control logic of a parallel NOR flash device. It sits behind an active-low bus made of chip enable, write enable, output enable and a hardware reset, with a 16-bit data path and a word address. All bus pins are sampled on a system clock. A write cycle is the clock edge at which the write strobe is first seen low while the chip is enabled and output enable is high. A read cycle starts at the clock edge at which the output strobe is first seen low while the chip is enabled.

The sequencer decodes multi-write unlock sequences for word program, sector erase, erase suspend and resume, and an unlock-bypass mode that shortens programming to two writes. The timed embedded operations are emulated with cycle counters. While one is running, the ready/busy pin is held low and reads return a status word with data polling on bit 7 and a toggle bit on bit 6. The storage is a small register array split into equal sectors. Programming can only clear bits, and erase sets a whole sector to ones. A parameter mask marks sectors as protected.

Top module: `nor_flash_ctrl`

## Requirements
- R1: While rst_n is low the sequencer returns to read-array mode, leaves unlock-bypass mode, aborts any running program or erase without changing the array, and releases ry_by_n high. With the bus idle (ce_n or oe_n high), rdata is zero.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0 and then the target address and data program one word. Only the low 8 bits of the data are compared against command codes, and the unlock addresses are compared on address bits 10:0. The stored word becomes its old value ANDed with the new data.
- R3: The unlock pair followed by 0x555/0x20 enters bypass mode. In bypass mode a write of 0xA0 to any address, followed by the address/data write, programs a word. Any other write in bypass mode leaves the mode, and after that a two-write program has no effect.
- R4: ry_by_n goes low in the cycle after the final write of a program or erase. It stays low for exactly PROG_CYC cycles for a program, or ERASE_CYC cycles for an erase that is not suspended, and is then released.
- R5: A read during a program returns the complement of data bit 7 of the word being programmed on rdata[7]. A read during an erase returns 0 on rdata[7]. In both cases every bit other than 7 and 6 is zero.
- R6: While busy, rdata[6] changes on every new read cycle.
- R7: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 and then any address inside a sector with data 0x30 erase that sector. The sector is word address bits 5:4 at the default size, and every word in it becomes 0xFFFF.
- R8: A program or erase aimed at a sector whose bit is set in PROT_MASK (sector 3 by default) does not start: ry_by_n stays high and the array is unchanged.
- R9: A write that does not match the next expected step of a sequence returns the sequencer to read-array mode, so the following writes do not complete the abandoned command.
- R10: Writing 0xB0 during an erase suspends it. ry_by_n goes high, words outside the erasing sector can be read and programmed, a program aimed at the erasing sector is ignored, and a read of that sector returns 0 on bit 7. Writing 0x30 resumes the erase, which then completes.
- R11: Writes that arrive while a program is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all bus pins are sampled |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data and command code |
| rdata | output | DATA_W | Array data or status word |
| ry_by_n | output | 1 | Ready (high) or busy (low) |

## Verification
The hardest state to reach is a suspended erase, because it needs a six-write erase in flight before the suspend write lands. The bench issues the erase, waits a few cycles, and suspends it. While suspended, it reads and programs a neighbouring sector, tries a program into the suspended sector, reads that sector's status, and then resumes the erase and checks that the whole sector ends at all ones. Unlock-bypass programming is swept over two full sectors using an arithmetic data pattern.

// File: rtl/nor_pkg.sv
package nor_pkg;

   typedef enum logic [3:0] {
      ST_READ,
      ST_UL1,
      ST_UL2,
      ST_PGM,
      ST_ER1,
      ST_ER2,
      ST_ER3,
      ST_BYP_PGM,
      ST_PBUSY,
      ST_EBUSY
   } seq_t;

   localparam logic [10:0] UL_ADDR1     = 11'h555;
   localparam logic [10:0] UL_ADDR2     = 11'h2AA;
   localparam logic [7:0]  UL_DATA1     = 8'hAA;
   localparam logic [7:0]  UL_DATA2     = 8'h55;
   localparam logic [7:0]  CMD_PGM      = 8'hA0;
   localparam logic [7:0]  CMD_ERS_SET  = 8'h80;
   localparam logic [7:0]  CMD_ERS_SECT = 8'h30;
   localparam logic [7:0]  CMD_BYPASS   = 8'h20;
   localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
   localparam logic [7:0]  CMD_RESUME   = 8'h30;

endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   localparam int CNT_W = $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= LOAD_VAL;
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = run && (cnt_q == '0);
endmodule

// File: rtl/nor_store.sv
module nor_store #(
   parameter int ARR_AW = 6,
   parameter int DATA_W = 16,
   parameter int SECT_W = 2
) (
   input  logic              clk,
   input  logic              pgm_we,
   input  logic [ARR_AW-1:0] pgm_addr,
   input  logic [DATA_W-1:0] pgm_data,
   input  logic              ers_we,
   input  logic [SECT_W-1:0] ers_sect,
   input  logic [ARR_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ARR_AW;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [ARR_AW-1:0] WADDR = ARR_AW'(w);
      localparam logic [SECT_W-1:0] WSECT = WADDR[ARR_AW-1 -: SECT_W];
      logic [DATA_W-1:0] word_q;

      always_ff @(posedge clk) begin
         if (ers_we && ers_sect == WSECT)
            word_q <= '1;
         else if (pgm_we && pgm_addr == WADDR)
            word_q <= word_q & pgm_data;
      end

      assign words[w] = word_q;
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
   import nor_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16,
   parameter int ARR_AW = 6,
   parameter int SECT_W = 2,
   parameter logic [(1<<SECT_W)-1:0] PROT_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pgm_done,
   input  logic              ers_done,
   output seq_t              state,
   output logic              susp,
   output logic              pgm_go,
   output logic              ers_go,
   output logic [ARR_AW-1:0] pgm_addr,
   output logic [DATA_W-1:0] pgm_data,
   output logic [SECT_W-1:0] ers_sect
);
   seq_t        nxt;
   logic        byp_q, nbyp, nsusp;
   logic [7:0]  code;
   logic        at_a1, at_a2, locked, in_ers;
   logic [SECT_W-1:0] wr_sect;

   assign code    = wr_data[7:0];
   assign at_a1   = wr_addr[10:0] == UL_ADDR1;
   assign at_a2   = wr_addr[10:0] == UL_ADDR2;
   assign wr_sect = wr_addr[ARR_AW-1 -: SECT_W];
   assign locked  = PROT_MASK[wr_sect];
   assign in_ers  = susp && (wr_sect == ers_sect);

   always_comb begin
      nxt    = state;
      nbyp   = byp_q;
      nsusp  = susp;
      pgm_go = 1'b0;
      ers_go = 1'b0;
      if (pgm_done) begin
         nxt = ST_READ;
      end else if (ers_done) begin
         nxt   = ST_READ;
         nsusp = 1'b0;
      end else if (wr_ev) begin
         case (state)
            ST_READ: begin
               if (byp_q) begin
                  if (code == CMD_PGM) nxt = ST_BYP_PGM;
                  else                 nbyp = 1'b0;
               end else if (susp && code == CMD_RESUME) begin
                  nxt   = ST_EBUSY;
                  nsusp = 1'b0;
               end else if (at_a1 && code == UL_DATA1) begin
                  nxt = ST_UL1;
               end
            end
            ST_UL1: nxt = (at_a2 && code == UL_DATA2) ? ST_UL2 : ST_READ;
            ST_UL2: begin
               nxt = ST_READ;
               if (at_a1) begin
                  if (code == CMD_PGM)
                     nxt = ST_PGM;
                  else if (code == CMD_BYPASS && !susp)
                     nbyp = 1'b1;
                  else if (code == CMD_ERS_SET && !susp)
                     nxt = ST_ER1;
               end
            end
            ST_PGM, ST_BYP_PGM: begin
               nxt = ST_READ;
               if (!locked && !in_ers) begin
                  nxt    = ST_PBUSY;
                  pgm_go = 1'b1;
               end
            end
            ST_ER1: nxt = (at_a1 && code == UL_DATA1) ? ST_ER2 : ST_READ;
            ST_ER2: nxt = (at_a2 && code == UL_DATA2) ? ST_ER3 : ST_READ;
            ST_ER3: begin
               nxt = ST_READ;
               if (code == CMD_ERS_SECT && !locked) begin
                  nxt    = ST_EBUSY;
                  ers_go = 1'b1;
               end
            end
            ST_EBUSY: begin
               if (code == CMD_SUSPEND) begin
                  nxt   = ST_READ;
                  nsusp = 1'b1;
               end
            end
            default: nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_READ;
         byp_q    <= 1'b0;
         susp     <= 1'b0;
         pgm_addr <= '0;
         pgm_data <= '0;
         ers_sect <= '0;
      end else begin
         state <= nxt;
         byp_q <= nbyp;
         susp  <= nsusp;
         if (pgm_go) begin
            pgm_addr <= wr_addr[ARR_AW-1:0];
            pgm_data <= wr_data;
         end
         if (ers_go)
            ers_sect <= wr_sect;
      end
   end
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
   import nor_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 16,
   parameter int ARR_AW    = 6,
   parameter int SECT_W    = 2,
   parameter int PROG_CYC  = 8,
   parameter int ERASE_CYC = 40,
   parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ry_by_n
);
   if (ADDR_W < 11) begin : g_bad_aw
      $error("ADDR_W must cover the unlock addresses");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must hold a command byte");
   end
   if (SECT_W < 1 || SECT_W > ARR_AW) begin : g_bad_sw
      $error("SECT_W must lie in 1..ARR_AW");
   end
   if (ARR_AW > ADDR_W || ARR_AW > 10) begin : g_bad_arr
      $error("ARR_AW too large");
   end
   if (PROG_CYC < 2 || ERASE_CYC < 2) begin : g_bad_cyc
      $error("operation lengths must be at least 2");
   end

   seq_t              state;
   logic              susp, pgm_go, ers_go, pgm_done, ers_done;
   logic              we_q, oe_q, wr_ev, rd_ev;
   logic              p_busy, e_busy, busy, tog_q;
   logic [ARR_AW-1:0] pgm_addr;
   logic [DATA_W-1:0] pgm_data, arr_rd, status;
   logic [SECT_W-1:0] ers_sect, rd_sect;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q <= 1'b1;
         oe_q <= 1'b1;
      end else begin
         we_q <= we_n;
         oe_q <= oe_n;
      end
   end

   assign wr_ev  = !ce_n && !we_n && we_q && oe_n;
   assign rd_ev  = !ce_n && !oe_n && oe_q;
   assign p_busy = state == ST_PBUSY;
   assign e_busy = state == ST_EBUSY;
   assign busy   = p_busy || e_busy;

   nor_seq_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW),
      .SECT_W(SECT_W), .PROT_MASK(PROT_MASK)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .wr_addr(addr),
      .wr_data(wdata), .pgm_done(pgm_done), .ers_done(ers_done),
      .state(state), .susp(susp), .pgm_go(pgm_go), .ers_go(ers_go),
      .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_sect(ers_sect)
   );

   nor_op_timer #(.CYCLES(PROG_CYC)) u_pgm_tmr (
      .clk(clk), .rst_n(rst_n), .load(pgm_go), .run(p_busy), .done(pgm_done)
   );

   nor_op_timer #(.CYCLES(ERASE_CYC)) u_ers_tmr (
      .clk(clk), .rst_n(rst_n), .load(ers_go), .run(e_busy), .done(ers_done)
   );

   nor_store #(.ARR_AW(ARR_AW), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_store (
      .clk(clk), .pgm_we(pgm_done), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
      .ers_we(ers_done), .ers_sect(ers_sect), .rd_addr(addr[ARR_AW-1:0]),
      .rd_data(arr_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tog_q <= 1'b0;
      else if (rd_ev && busy)
         tog_q <= ~tog_q;
   end

   assign rd_sect = addr[ARR_AW-1 -: SECT_W];

   always_comb begin
      status    = '0;
      status[7] = p_busy ? ~pgm_data[7] : 1'b0;
      status[6] = tog_q;
   end

   always_comb begin
      if (ce_n || oe_n)
         rdata = '0;
      else if (busy || (susp && rd_sect == ers_sect))
         rdata = status;
      else
         rdata = arr_rd;
   end

   assign ry_by_n = !busy;
endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk #(
   parameter int DATA_W    = 16,
   parameter int ERASE_CYC = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] rdata,
   input logic              ry_by_n,
   input logic              e_busy,
   input logic              rd_ev
);
   localparam int CW = $clog2(ERASE_CYC + 2) + 1;
   logic [CW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run <= '0;
      else if (ry_by_n)
         low_run <= '0;
      else
         low_run <= low_run + 1'b1;
   end

   p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ry_by_n);

   p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= CW'(ERASE_CYC));

   p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (e_busy && !ce_n && !oe_n) |-> (rdata[7] == 1'b0));

   p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && !ry_by_n) |=> (oe_n || ce_n || ry_by_n || rdata[6] != $past(rdata[6])));
endmodule

bind nor_flash_ctrl nor_flash_chk #(.DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rdata(rdata),
   .ry_by_n(ry_by_n), .e_busy(e_busy), .rd_ev(rd_ev)
);

// File: tb/nor_flash_ctrl_tb.sv
module nor_flash_ctrl_tb;
   localparam int PROG_CYC  = 8;
   localparam int ERASE_CYC = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [10:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        ry_by_n;

   int nchk = 0;
   int nfail = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   nor_flash_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ry_by_n(ry_by_n)
   );

   function automatic logic [15:0] pat(int w);
      return 16'((w * 2871) ^ 23130);
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [10:0] a, logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic rd(logic [10:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      @(negedge clk);
      v = rdata;
      oe_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ry_by_n && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic prog(logic [10:0] a, logic [15:0] d);
      wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'hA0); wr(a, d);
   endtask

   task automatic erase(int s);
      wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'h80);
      wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'(s * 16), 16'h30);
   endtask

   task automatic byp_enter();
      wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'h20);
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  %0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] v, v1, v2, old;
      int n;

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 ready in reset", 16'(ry_by_n), 16'h1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", 16'(ry_by_n), 16'h1);
      check("R1 idle bus reads zero", rdata, 16'h0);

      // R7 / R4 erase sectors 0..2
      for (int s = 0; s < 3; s++) begin
         erase(s);
         wait_ready(n);
         check("R4 erase busy length", 16'(n), 16'(ERASE_CYC));
         for (int w = s * 16; w < s * 16 + 16; w++) begin
            rd(11'(w), v);
            check("R7 erased word", v, 16'hFFFF);
         end
      end

      // R2 normal program and AND behaviour
      prog(11'd5, 16'h1234);
      wait_ready(n);
      check("R4 program busy length", 16'(n), 16'(PROG_CYC));
      rd(11'd5, v);
      check("R2 programmed word", v, 16'h1234);
      prog(11'd5, 16'hF0FF);
      wait_ready(n);
      rd(11'd5, v);
      check("R2 program ANDs", v, 16'h1234 & 16'hF0FF);

      // R5 / R6 status reads while programming
      prog(11'd6, 16'h0080);
      rd(11'd6, v1);
      rd(11'd6, v2);
      check("R5 poll bit7 complement", 16'(v1[7]), 16'h0);
      check("R5 other status bits zero", v1 & 16'hFF3F, 16'h0);
      check("R6 toggle differs", 16'(v1[6] ^ v2[6]), 16'h1);
      wait_ready(n);
      rd(11'd6, v);
      check("R2 word after status reads", v, 16'h0080);
      prog(11'd7, 16'h0000);
      rd(11'd7, v1);
      check("R5 poll bit7 for zero data", 16'(v1[7]), 16'h1);
      wait_ready(n);

      // R11 writes during busy ignored
      prog(11'd9, 16'hAAAA);
      wr(11'd9, 16'h0000);
      wait_ready(n);
      rd(11'd9, v);
      check("R11 write while busy ignored", v, 16'hAAAA);

      // R3 bypass sweep over sectors 1 and 2
      byp_enter();
      for (int w = 16; w < 48; w++) begin
         wr(11'd0, 16'hA0);
         wr(11'(w), pat(w));
         wait_ready(n);
      end
      wr(11'd0, 16'hF0);
      for (int w = 16; w < 48; w++) begin
         rd(11'(w), v);
         check("R3 bypass program", v, pat(w));
      end
      wr(11'd0, 16'hA0);
      wr(11'd20, 16'h0000);
      check("R3 no busy after bypass exit", 16'(ry_by_n), 16'h1);
      rd(11'd20, v);
      check("R3 two-write program after exit", v, pat(20));

      // R9 broken sequence
      wr(11'h555, 16'hAA); wr(11'h2AA, 16'h56); wr(11'h555, 16'hA0); wr(11'd8, 16'h0000);
      check("R9 no busy after broken sequence", 16'(ry_by_n), 16'h1);
      rd(11'd8, v);
      check("R9 word untouched", v, 16'hFFFF);
      prog(11'd8, 16'h00FF);
      wait_ready(n);
      rd(11'd8, v);
      check("R9 later program works", v, 16'h00FF);

      // R8 protected sector 3
      rd(11'd50, old);
      prog(11'd50, 16'h0000);
      check("R8 program protected no busy", 16'(ry_by_n), 16'h1);
      rd(11'd50, v);
      check("R8 protected word unchanged", v, old);
      erase(3);
      check("R8 erase protected no busy", 16'(ry_by_n), 16'h1);
      rd(11'd50, v);
      check("R8 protected word after erase", v, old);

      // R10 erase suspend / resume on sector 2
      erase(2);
      repeat (5) @(negedge clk);
      check("R10 erase running", 16'(ry_by_n), 16'h0);
      rd(11'd34, v);
      check("R5 erase poll bit7", 16'(v[7]), 16'h0);
      wr(11'd0, 16'hB0);
      check("R10 ready when suspended", 16'(ry_by_n), 16'h1);
      rd(11'd16, v);
      check("R10 read other sector", v, pat(16));
      prog(11'd17, 16'h0F0F);
      wait_ready(n);
      check("R10 program in suspend length", 16'(n), 16'(PROG_CYC));
      rd(11'd17, v);
      check("R10 program other sector", v, pat(17) & 16'h0F0F);
      prog(11'd33, 16'h0000);
      check("R10 program erasing sector ignored", 16'(ry_by_n), 16'h1);
      rd(11'd33, v);
      check("R10 suspended sector status bit7", 16'(v[7]), 16'h0);
      wr(11'd0, 16'h30);
      check("R10 resume busy", 16'(ry_by_n), 16'h0);
      wait_ready(n);
      for (int w = 32; w < 48; w++) begin
         rd(11'(w), v);
         check("R10 resumed erase completes", v, 16'hFFFF);
      end
      rd(11'd17, v);
      check("R10 other sector kept", v, pat(17) & 16'h0F0F);

      // R1 abort program by reset
      prog(11'd10, 16'h0000);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 ready during reset", 16'(ry_by_n), 16'h1);
      rst_n = 1'b1;
      @(negedge clk);
      rd(11'd10, v);
      check("R1 aborted program leaves word", v, 16'hFFFF);

      // R1 reset leaves bypass
      byp_enter();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wr(11'd0, 16'hA0);
      wr(11'd11, 16'h0000);
      check("R1 no bypass program after reset", 16'(ry_by_n), 16'h1);
      rd(11'd11, v);
      check("R1 bypass cleared", v, 16'hFFFF);

      finish_run();
   end
endmodule